// File: doc/BRIEF.md
# Converter Busy and Interrupt Status Generator

This block drives the single status pin of a six-input converter model built as three channel pairs that sample together. Each pair has its own start input. A counter that runs for a set number of conversion-clock cycles takes the place of the analog conversion. One output pin shows one of three things: a busy level that covers the whole conversion, a busy level with a one-cycle low notch each time a pair finishes (sequential mode), or an interrupt flag that stays set until the result is read. A polarity control can invert any of these. Each pair also reports a partial power-down flag. The flag is set when that pair's start level falls before its conversion has finished.

Four mode inputs configure the block. `cfg_sw_i` selects software mode, in which the start input of pair 0 launches every pair at once. `cfg_seq_i` selects sequential mode, in which each pair starts from its own input and its completion shows as a notch. `cfg_int_i` selects the interrupt signalling, and `cfg_pol_i` inverts the output. The reset input is qualified: it acts only after it has stayed high for `RST_MIN` consecutive clock edges.

Each pair runs an FSM with the states PAIR_IDLE, PAIR_CONV and PAIR_PDOWN. A trigger moves it from idle or power-down into conversion. A falling start level moves it from conversion to power-down. The end of the count moves it from conversion back to idle. The status FSM has the states ST_IDLE, ST_BUSY, ST_SEQGAP, ST_WAIT and ST_INT:
- From ST_IDLE, a started pair leads to ST_BUSY, or to ST_WAIT in interrupt mode.
- ST_BUSY goes to ST_SEQGAP when a pair completes in sequential mode. It goes to ST_IDLE when no pair is left converting.
- ST_SEQGAP always lasts one cycle. It returns to ST_BUSY or ST_WAIT if a pair is still converting, and otherwise to ST_IDLE.
- ST_WAIT goes to ST_INT when the last pair completes, or to ST_IDLE if the last pair was aborted.
- ST_INT leaves only on a read strobe, going to ST_WAIT if a pair is converting and otherwise to ST_IDLE.

Top module: `cvst_irq`

## Requirements
- R1: In busy mode (`cfg_int_i`=0, `cfg_seq_i`=0, `cfg_pol_i`=0), the output is 1 from the clock edge that accepts a start until exactly `CONV_CYC` edges later, when the last active pair finishes. After that it is 0.
- R2: In sequential mode (`cfg_seq_i`=1), the output is 1 while any pair converts. It is 0 for exactly one cycle starting at each pair's completion edge, and it returns to 1 if another pair is still converting.
- R3: In interrupt mode (`cfg_int_i`=1), the output is 0 while pairs convert. It becomes 1 at the edge where the last pair completes and stays 1 until an edge that samples `rd_i`=1, after which it is 0.
- R4: With `cfg_pol_i`=1, the output is the logical inverse of the level that R1 to R3 describe, including the idle level of 1.
- R5: In hardware mode (`cfg_sw_i`=0), a rising edge on `start_i[k]` starts pair k only. Pairs run independently, and the busy level stays until the last running pair finishes.
- R6: In software mode without sequencing (`cfg_sw_i`=1, `cfg_seq_i`=0), a rising edge on `start_i[0]` starts all pairs, and rising edges on the other start bits have no effect.
- R7: In hardware mode, if `start_i[k]` is sampled low while pair k converts, the conversion is aborted and `pdown_o[k]` becomes 1 at that edge. The flag stays set until the next rising edge on `start_i[k]`, which clears it and starts a new conversion.
- R8: A start edge that arrives while its pair is still converting is ignored and does not extend the conversion.
- R9: `rst_i` takes effect only at the `RST_MIN`-th consecutive edge at which it is sampled high. It then aborts every conversion. A shorter pulse has no effect.
- R10: After reset, the output is at its inactive level (0 when `cfg_pol_i`=0) and every `pdown_o` bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Conversion clock |
| rst_i | input | 1 | Active-high reset request, qualified by minimum width |
| start_i | input | NUM_PAIRS | Per-pair conversion-start levels |
| rd_i | input | 1 | Result-read strobe, clears the interrupt |
| cfg_sw_i | input | 1 | Software mode select |
| cfg_seq_i | input | 1 | Sequential mode select |
| cfg_int_i | input | 1 | Interrupt signalling select |
| cfg_pol_i | input | 1 | Output polarity inversion |
| busy_int_o | output | 1 | Busy or interrupt status pin |
| pdown_o | output | NUM_PAIRS | Per-pair partial power-down flags |

## Verification
The hardest situation to reach from the ports is a reset pulse that lands in the middle of a conversion and is exactly one edge too short or exactly long enough. The bench uses sequential software mode, so that lowering a start level cannot trigger a power-down. It pulses pair 0, raises reset for `RST_MIN`-1 edges and then for `RST_MIN` edges, and checks that the output stays high in the first case and falls at exactly the qualifying edge in the second. The one-cycle notches are placed by starting the second pair two edges after the first, so that the two completions fall at distinct edges that can be predicted.

// File: rtl/cvst_pkg.sv
package cvst_pkg;

    typedef enum logic [1:0] {
        PAIR_IDLE,
        PAIR_CONV,
        PAIR_PDOWN
    } pair_st_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUSY,
        ST_SEQGAP,
        ST_WAIT,
        ST_INT
    } stat_st_t;

endpackage

// File: rtl/cvst_rst_qual.sv
module cvst_rst_qual #(
    parameter int RST_MIN = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic srst_o
);

    localparam int CW = (RST_MIN > 2) ? $clog2(RST_MIN) : 1;
    localparam logic [CW-1:0] LAST = CW'(RST_MIN - 1);

    logic [CW-1:0] cnt_q = '0;

    // consecutive high edges, saturating one short of the limit
    always_ff @(posedge clk_i) begin
        if (!rst_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign srst_o = rst_i && (cnt_q == LAST);

    // R9: a qualified reset is always preceded by a high request
    p_rst_width_r9: assert property (@(posedge clk_i) disable iff (!rst_i)
        srst_o |-> $past(rst_i));

endmodule

// File: rtl/cvst_pair.sv
module cvst_pair
    import cvst_pkg::*;
#(
    parameter int CONV_CYC = 16
) (
    input  logic clk_i,
    input  logic srst_i,
    input  logic trig_i,
    input  logic lvl_i,
    input  logic fall_chk_i,
    output logic conv_nxt_o,
    output logic done_o,
    output logic pdown_o
);

    localparam int CW = (CONV_CYC > 2) ? $clog2(CONV_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(CONV_CYC - 1);

    pair_st_t      state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          abort;
    logic          at_end;
    logic          conv;

    assign abort  = fall_chk_i && !lvl_i;
    assign at_end = (cnt_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PAIR_IDLE:  if (trig_i) state_d = PAIR_CONV;
            PAIR_CONV: begin
                if (abort)       state_d = PAIR_PDOWN;
                else if (at_end) state_d = PAIR_IDLE;
            end
            PAIR_PDOWN: if (trig_i) state_d = PAIR_CONV;
            default:    state_d = PAIR_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            state_q <= PAIR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != PAIR_CONV) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    always_comb begin
        conv       = (state_q == PAIR_CONV);
        conv_nxt_o = (state_d == PAIR_CONV);
        done_o     = conv && at_end && !abort;
        pdown_o    = (state_q == PAIR_PDOWN);
    end

    // R7: power-down is only ever entered from an active conversion
    p_pdown_from_conv_r7: assert property (@(posedge clk_i) disable iff (srst_i)
        $rose(pdown_o) |-> $past(conv));

    // R8: a trigger during an unfinished conversion keeps it running
    p_retrig_ignored_r8: assert property (@(posedge clk_i) disable iff (srst_i)
        (conv && trig_i && !at_end && !abort) |=> conv);

endmodule

// File: rtl/cvst_status.sv
module cvst_status
    import cvst_pkg::*;
#(
    parameter int NUM_PAIRS = 3
) (
    input  logic                 clk_i,
    input  logic                 srst_i,
    input  logic                 cfg_seq_i,
    input  logic                 cfg_int_i,
    input  logic                 cfg_pol_i,
    input  logic                 rd_i,
    input  logic [NUM_PAIRS-1:0] conv_nxt_i,
    input  logic [NUM_PAIRS-1:0] done_i,
    output logic                 irq_o
);

    stat_st_t state_q, state_d;
    logic     any_nxt;
    logic     any_done;
    stat_st_t run_st;
    logic     raw;

    assign any_nxt  = |conv_nxt_i;
    assign any_done = |done_i;
    assign run_st   = cfg_int_i ? ST_WAIT : ST_BUSY;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any_nxt) state_d = run_st;
            ST_BUSY: begin
                if (cfg_seq_i && any_done) state_d = ST_SEQGAP;
                else if (!any_nxt)         state_d = ST_IDLE;
            end
            ST_SEQGAP: state_d = any_nxt ? run_st : ST_IDLE;
            ST_WAIT: begin
                if (!any_nxt) state_d = any_done ? ST_INT : ST_IDLE;
            end
            ST_INT: begin
                if (rd_i) state_d = any_nxt ? ST_WAIT : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        raw   = (state_q == ST_BUSY) || (state_q == ST_INT);
        irq_o = raw ^ cfg_pol_i;
    end

    // R2: the completion notch lasts a single cycle
    p_seqgap_one_r2: assert property (@(posedge clk_i) disable iff (srst_i)
        (state_q == ST_SEQGAP) |=> (state_q != ST_SEQGAP));

    // R3: the interrupt holds until a read strobe is seen
    p_int_hold_r3: assert property (@(posedge clk_i) disable iff (srst_i)
        (state_q == ST_INT && !rd_i) |=> (state_q == ST_INT));

endmodule

// File: rtl/cvst_irq.sv
module cvst_irq #(
    parameter int NUM_PAIRS = 3,
    parameter int CONV_CYC  = 16,
    parameter int RST_MIN   = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [NUM_PAIRS-1:0] start_i,
    input  logic                 rd_i,
    input  logic                 cfg_sw_i,
    input  logic                 cfg_seq_i,
    input  logic                 cfg_int_i,
    input  logic                 cfg_pol_i,
    output logic                 busy_int_o,
    output logic [NUM_PAIRS-1:0] pdown_o
);

    logic                 srst;
    logic [NUM_PAIRS-1:0] start_q;
    logic [NUM_PAIRS-1:0] rise;
    logic [NUM_PAIRS-1:0] trig;
    logic [NUM_PAIRS-1:0] conv_nxt;
    logic [NUM_PAIRS-1:0] done;
    logic                 gang;

    cvst_rst_qual #(.RST_MIN(RST_MIN)) rq_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .srst_o (srst)
    );

    always_ff @(posedge clk_i) begin
        if (srst) begin
            start_q <= '0;
        end else begin
            start_q <= start_i;
        end
    end

    assign rise = start_i & ~start_q;
    assign gang = cfg_sw_i && !cfg_seq_i;

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        if (g == 0) begin : g_lead
            assign trig[g] = rise[0];
        end else begin : g_follow
            assign trig[g] = gang ? rise[0] : rise[g];
        end

        cvst_pair #(.CONV_CYC(CONV_CYC)) pair_i (
            .clk_i      (clk_i),
            .srst_i     (srst),
            .trig_i     (trig[g]),
            .lvl_i      (start_i[g]),
            .fall_chk_i (!cfg_sw_i),
            .conv_nxt_o (conv_nxt[g]),
            .done_o     (done[g]),
            .pdown_o    (pdown_o[g])
        );
    end

    cvst_status #(.NUM_PAIRS(NUM_PAIRS)) stat_i (
        .clk_i      (clk_i),
        .srst_i     (srst),
        .cfg_seq_i  (cfg_seq_i),
        .cfg_int_i  (cfg_int_i),
        .cfg_pol_i  (cfg_pol_i),
        .rd_i       (rd_i),
        .conv_nxt_i (conv_nxt),
        .done_i     (done),
        .irq_o      (busy_int_o)
    );

endmodule

// File: tb/cvst_irq_tb_top.sv
module cvst_irq_tb_top;

    localparam int CLK_P = 10;
    localparam int NP    = 3;
    localparam int N     = 16;
    localparam int M     = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] start;
    logic          rd;
    logic          sw, seq, intm, pol;
    logic          out;
    logic [NP-1:0] pdn;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    cvst_irq #(.NUM_PAIRS(NP), .CONV_CYC(N), .RST_MIN(M)) dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .start_i    (start),
        .rd_i       (rd),
        .cfg_sw_i   (sw),
        .cfg_seq_i  (seq),
        .cfg_int_i  (intm),
        .cfg_pol_i  (pol),
        .busy_int_o (out),
        .pdown_o    (pdn)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic s, input logic q, input logic i, input logic p);
        sw = s; seq = q; intm = i; pol = p;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        ticks(M + 2);
        rst = 1'b0;
        tick();
        chk("R10 output idle after reset", 8'(out), 8'h0);
        chk("R10 pdown clear after reset", 8'(pdn), 8'h0);
    endtask

    task automatic t_busy();
        set_cfg(0, 0, 0, 0);
        start = 3'b001;
        tick();
        chk("R1 high at start edge", 8'(out), 8'h1);
        ticks(N - 1);
        chk("R1 high on last cycle", 8'(out), 8'h1);
        tick();
        chk("R1 low after conversion", 8'(out), 8'h0);
        start = '0;
        ticks(2);
    endtask

    task automatic t_pairs();
        set_cfg(0, 0, 0, 0);
        start = 3'b001;
        ticks(3);
        start = 3'b011;
        ticks(N - 2);
        chk("R5 busy held while pair 1 runs", 8'(out), 8'h1);
        chk("R5 no power-down", 8'(pdn), 8'h0);
        ticks(2);
        chk("R5 busy on pair 1 last cycle", 8'(out), 8'h1);
        tick();
        chk("R5 low after pair 1 finishes", 8'(out), 8'h0);
        start = '0;
        ticks(2);
    endtask

    task automatic t_seq();
        set_cfg(1, 1, 0, 0);
        start = 3'b001;
        tick();
        start = '0;
        tick();
        start = 3'b010;
        tick();
        start = '0;
        ticks(N - 3);
        chk("R2 high before first completion", 8'(out), 8'h1);
        tick();
        chk("R2 notch at pair 0 completion", 8'(out), 8'h0);
        tick();
        chk("R2 high again after notch", 8'(out), 8'h1);
        tick();
        chk("R2 notch at pair 1 completion", 8'(out), 8'h0);
        tick();
        chk("R2 low when all done", 8'(out), 8'h0);
        ticks(2);
    endtask

    task automatic t_retrig();
        set_cfg(1, 1, 0, 0);
        start = 3'b001;
        tick();
        start = '0;
        ticks(2);
        start = 3'b001;
        tick();
        start = '0;
        ticks(N - 4);
        chk("R8 high before completion", 8'(out), 8'h1);
        tick();
        chk("R8 completes on original schedule", 8'(out), 8'h0);
        tick();
        chk("R8 second edge not started", 8'(out), 8'h0);
        ticks(3);
    endtask

    task automatic t_gang();
        set_cfg(1, 0, 0, 0);
        start = 3'b110;
        tick();
        start = '0;
        tick();
        chk("R6 other start bits ignored", 8'(out), 8'h0);
        start = 3'b001;
        tick();
        chk("R6 pair 0 start launches", 8'(out), 8'h1);
        start = '0;
        ticks(N - 1);
        chk("R6 high on last cycle", 8'(out), 8'h1);
        tick();
        chk("R6 low after all pairs done", 8'(out), 8'h0);
        ticks(2);
    endtask

    task automatic t_int();
        set_cfg(0, 0, 1, 0);
        start = 3'b001;
        tick();
        chk("R3 low at conversion start", 8'(out), 8'h0);
        ticks(N - 1);
        chk("R3 low on last conversion cycle", 8'(out), 8'h0);
        tick();
        chk("R3 set at completion", 8'(out), 8'h1);
        start = '0;
        ticks(5);
        chk("R3 held until read", 8'(out), 8'h1);
        rd = 1'b1;
        tick();
        rd = 1'b0;
        chk("R3 cleared by read", 8'(out), 8'h0);
        tick();
        chk("R3 stays clear", 8'(out), 8'h0);
    endtask

    task automatic t_pol();
        set_cfg(0, 0, 0, 1);
        tick();
        chk("R4 inverted idle level", 8'(out), 8'h1);
        start = 3'b001;
        tick();
        chk("R4 inverted busy level", 8'(out), 8'h0);
        ticks(N - 1);
        chk("R4 inverted on last cycle", 8'(out), 8'h0);
        tick();
        chk("R4 inverted after completion", 8'(out), 8'h1);
        start = '0;
        pol = 1'b0;
        ticks(2);
    endtask

    task automatic t_pdown();
        set_cfg(0, 0, 0, 0);
        start = 3'b100;
        tick();
        chk("R7 pair 2 busy", 8'(out), 8'h1);
        ticks(2);
        start = '0;
        tick();
        chk("R7 power-down on early fall", 8'(pdn), 8'h4);
        chk("R7 busy released on abort", 8'(out), 8'h0);
        ticks(3);
        chk("R7 power-down held", 8'(pdn), 8'h4);
        start = 3'b100;
        tick();
        chk("R7 flag cleared by new start", 8'(pdn), 8'h0);
        chk("R7 new conversion running", 8'(out), 8'h1);
        ticks(N);
        chk("R7 restarted conversion ends", 8'(out), 8'h0);
        start = '0;
        ticks(2);
    endtask

    task automatic t_rst_short();
        set_cfg(1, 1, 0, 0);
        start = 3'b001;
        tick();
        start = '0;
        tick();
        rst = 1'b1;
        ticks(M - 1);
        rst = 1'b0;
        ticks(N - 1 - M);
        chk("R9 short pulse ignored", 8'(out), 8'h1);
        tick();
        chk("R9 normal completion after short pulse", 8'(out), 8'h0);
        ticks(3);
    endtask

    task automatic t_rst_full();
        set_cfg(1, 1, 0, 0);
        start = 3'b001;
        tick();
        start = '0;
        tick();
        rst = 1'b1;
        ticks(M - 1);
        chk("R9 still busy before qualification", 8'(out), 8'h1);
        tick();
        chk("R9 qualified reset aborts", 8'(out), 8'h0);
        rst = 1'b0;
        ticks(N);
        chk("R9 no resumed conversion", 8'(out), 8'h0);
        chk("R10 pdown clear after abort", 8'(pdn), 8'h0);
    endtask

    initial begin
        rst = 1'b1;
        start = '0;
        rd = 1'b0;
        set_cfg(0, 0, 0, 0);
        t_reset();
        t_busy();
        t_pairs();
        t_seq();
        t_retrig();
        t_gang();
        t_int();
        t_pol();
        t_pdown();
        t_rst_short();
        t_rst_full();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule